// File: doc/BRIEF.md
# Character Display Power-Up Sequencer

This block brings a character display controller out of power-up by issuing its fixed start-up instruction list, with no help from the busy flag. During this phase the flag cannot be read, so every instruction is followed by a fixed wait. Each wait is a parameter counted in clock cycles and should be set with margin above the controller's minimum. The interface width is chosen at build time. In the 8-bit form each instruction is one bus cycle. In the 4-bit form the sequence opens with a lone wake-up nibble, and every later instruction goes out as two nibbles: the upper half first, then the lower half. Both travel on data lines 7..4, one bus cycle per nibble.

Each bus cycle is handed to a downstream strobe engine through a valid/ready request: `req_valid` with `req_data`, accepted on a rising edge where `req_ready` is also high. The line-count and font bits of function set, and the direction and shift bits of entry mode, are taken from configuration pins while reset is held. When the last wait has elapsed, `init_done` goes high and stays high until the next reset. A reset at any point restarts the whole sequence, beginning with the power-up wait.

Top module: `lcdi_init_seq`

## Requirements
- R1: While reset is held, `req_valid` and `init_done` are low. After release, `req_valid` stays low for exactly `PWR_CYC` clock cycles before the first request.
- R2: With `WIDE_BUS`=1 the accepted bytes are, in order: function set `0011_N_F_00` (N = bit 3, F = bit 2), display control `00001_D_C_B` (from `DCB_BITS`), clear `0000_0001`, and entry mode `000001_I_S` (I = bit 1, S = bit 0).
- R3: With `WIDE_BUS`=0 the first accepted cycle is the lone nibble `0010`. It is followed by function set `0010_N_F_00`, display control, clear and entry mode, each sent as upper nibble then lower nibble. Every nibble sits in `req_data[7:4]`, and `req_data[3:0]` is zero.
- R4: Once raised, a request keeps `req_valid` high and `req_data` unchanged until it is accepted.
- R5: After an accepted instruction, `req_valid` is low for exactly the wait that belongs to it before the next request. The waits are `FS_CYC` after function set, `CLR_CYC` after clear, and `SHORT_CYC` after display control and after the lone nibble.
- R6: In 4-bit mode the lower nibble is presented in the cycle right after its upper nibble is accepted, with no wait between them.
- R7: `init_done` rises exactly `SHORT_CYC` cycles after entry mode is accepted. From then on it stays high and no further request is raised.
- R8: The configuration pins are captured while reset is held. Changes to them after release have no effect on the bytes sent.
- R9: A reset in the middle of the sequence drops `init_done` and any pending request. After release the whole sequence runs again from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the sequence |
| cfg_lines | input | 1 | Line-count bit of function set |
| cfg_font | input | 1 | Font bit of function set |
| cfg_incr | input | 1 | Cursor-direction bit of entry mode |
| cfg_shift | input | 1 | Display-shift bit of entry mode |
| req_ready | input | 1 | Strobe engine accepts the pending request |
| req_valid | output | 1 | A bus cycle is requested |
| req_data | output | 8 | Instruction byte, or nibble on bits 7..4 |
| init_done | output | 1 | Start-up sequence complete |

## Verification
The assertions allow `req_ready` to rise in any cycle and for any length of stall. They do rely on reset being held for at least one clock edge, so that the captured configuration and the power-up wait are loaded. The bench's ready responder raises `req_ready` only while a request is pending. It drops it in the cycle after each acceptance and delays it by a chosen number of cycles, so each timing check can compare a wait against its exact expected length. Configuration pins change only while reset is held, except in the one scenario written to show that a change after release is ignored.

// File: rtl/lcdi_pkg.sv
// Shared types and instruction builders for the display power-up sequencer.
// Assumes: none beyond IEEE 1800-2017 packages.
package lcdi_pkg;

    localparam int STEP_W = 3;

    // Which fixed wait follows an instruction.
    typedef enum logic [1:0] {
        WT_SHORT = 2'd0,
        WT_FS    = 2'd1,
        WT_CLR   = 2'd2
    } wait_sel_e;

    // One entry of the start-up list.
    typedef struct packed {
        logic [7:0] code;
        logic       single;   // send upper nibble only (4-bit wake-up)
        wait_sel_e  wsel;
    } step_t;

    // Captured configuration bits.
    typedef struct packed {
        logic lines;
        logic font;
        logic incr;
        logic shift;
    } cfg_t;

    typedef enum logic [1:0] {
        SQ_POWER = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_GAP   = 2'd2,
        SQ_DONE  = 2'd3
    } sq_state_e;

    // Function set: bit 4 picks bus width, bit 3 lines, bit 2 font.
    function automatic logic [7:0] op_function(input logic wide, input cfg_t c);
        return {3'b001, wide, c.lines, c.font, 2'b00};
    endfunction

    function automatic logic [7:0] op_display(input logic [2:0] dcb);
        return {5'b00001, dcb};
    endfunction

    function automatic logic [7:0] op_entry(input cfg_t c);
        return {6'b000001, c.incr, c.shift};
    endfunction

    localparam logic [7:0] OP_CLEAR = 8'h01;
    localparam logic [7:0] OP_WAKE4 = 8'h20;

endpackage

// File: rtl/lcdi_step_table.sv
// Start-up instruction list, indexed by step number.
// Assumes: idx never exceeds the last step; the caller stops at 'last'.
module lcdi_step_table
    import lcdi_pkg::*;
#(
    parameter bit         WIDE_BUS = 1'b1,
    parameter logic [2:0] DCB_BITS = 3'b100
) (
    input  cfg_t              cfg,
    input  logic [STEP_W-1:0] idx,
    output step_t             step,
    output logic              last
);

    generate
        if (WIDE_BUS) begin : g_wide
            // Four single-cycle instructions.
            always_comb begin
                step = '{code: op_function(1'b1, cfg), single: 1'b0, wsel: WT_FS};
                last = 1'b0;
                case (idx)
                    3'd0: step = '{code: op_function(1'b1, cfg), single: 1'b0, wsel: WT_FS};
                    3'd1: step = '{code: op_display(DCB_BITS),   single: 1'b0, wsel: WT_SHORT};
                    3'd2: step = '{code: OP_CLEAR,               single: 1'b0, wsel: WT_CLR};
                    default: begin
                        step = '{code: op_entry(cfg), single: 1'b0, wsel: WT_SHORT};
                        last = 1'b1;
                    end
                endcase
            end
        end else begin : g_narrow
            // Lone wake-up nibble, then four split instructions.
            always_comb begin
                step = '{code: OP_WAKE4, single: 1'b1, wsel: WT_SHORT};
                last = 1'b0;
                case (idx)
                    3'd0: step = '{code: OP_WAKE4,               single: 1'b1, wsel: WT_SHORT};
                    3'd1: step = '{code: op_function(1'b0, cfg), single: 1'b0, wsel: WT_FS};
                    3'd2: step = '{code: op_display(DCB_BITS),   single: 1'b0, wsel: WT_SHORT};
                    3'd3: step = '{code: OP_CLEAR,               single: 1'b0, wsel: WT_CLR};
                    default: begin
                        step = '{code: op_entry(cfg), single: 1'b0, wsel: WT_SHORT};
                        last = 1'b1;
                    end
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/lcdi_wait_timer.sv
// Down-counter for fixed waits; 'expired' when it has reached zero.
// Assumes: a load of value V makes expired rise V cycles later.
module lcdi_wait_timer #(
    parameter int          CNT_W   = 8,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count toward zero; reset arms the power-up wait.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= RST_VAL;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
    AST_TIMER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired); // R5

endmodule

// File: rtl/lcdi_nibble_lane.sv
// Places one half of a byte on data lines 7..4 for a 4-bit bus.
// Assumes: phase 0 is the upper half, phase 1 the lower half.
module lcdi_nibble_lane (
    input  logic [7:0] code,
    input  logic       phase,
    output logic [7:0] lane
);

    // Select the half and clear the unused lines.
    always_comb begin
        lane = phase ? {code[3:0], 4'b0000} : {code[7:4], 4'b0000};
    end

endmodule

// File: rtl/lcdi_init_seq.sv
// Power-up sequencer: power wait, then each list entry as a bus request
// followed by its fixed wait, then init_done.
// Assumes: every wait parameter is at least 1; configuration is captured
// while rst_n is low.
module lcdi_init_seq
    import lcdi_pkg::*;
#(
    parameter bit         WIDE_BUS  = 1'b1,
    parameter int         PWR_CYC   = 2_100_000,
    parameter int         FS_CYC    = 2_100,
    parameter int         SHORT_CYC = 2_100,
    parameter int         CLR_CYC   = 80_000,
    parameter logic [2:0] DCB_BITS  = 3'b100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_lines,
    input  logic       cfg_font,
    input  logic       cfg_incr,
    input  logic       cfg_shift,
    input  logic       req_ready,
    output logic       req_valid,
    output logic [7:0] req_data,
    output logic       init_done
);

    localparam int MAX_A = (PWR_CYC > FS_CYC) ? PWR_CYC : FS_CYC;
    localparam int MAX_B = (SHORT_CYC > CLR_CYC) ? SHORT_CYC : CLR_CYC;
    localparam int MAX_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_W + 1);

    cfg_t              cfg_q;
    sq_state_e         state_q;
    logic [STEP_W-1:0] idx_q;
    logic              phase_q;
    step_t             step;
    logic              last;
    logic              accept;
    logic              more_nibble;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_expired;

    // Capture configuration while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '{lines: cfg_lines, font: cfg_font, incr: cfg_incr, shift: cfg_shift};
    end

    lcdi_step_table #(.WIDE_BUS(WIDE_BUS), .DCB_BITS(DCB_BITS)) u_table (
        .cfg  (cfg_q),
        .idx  (idx_q),
        .step (step),
        .last (last)
    );

    assign accept      = req_valid && req_ready;
    assign more_nibble = !WIDE_BUS && !step.single && !phase_q;
    assign t_load      = accept && !more_nibble;

    // Wait length of the current entry, minus one for the load cycle.
    always_comb begin
        case (step.wsel)
            WT_FS:   t_val = CNT_W'(FS_CYC - 1);
            WT_CLR:  t_val = CNT_W'(CLR_CYC - 1);
            default: t_val = CNT_W'(SHORT_CYC - 1);
        endcase
    end

    lcdi_wait_timer #(.CNT_W(CNT_W), .RST_VAL(CNT_W'(PWR_CYC - 1))) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    // Sequence control: power wait, issue, gap, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_POWER;
            idx_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            case (state_q)
                SQ_POWER: if (t_expired) state_q <= SQ_ISSUE;
                SQ_ISSUE: if (accept) begin
                    if (more_nibble) begin
                        phase_q <= 1'b1;
                    end else begin
                        phase_q <= 1'b0;
                        state_q <= SQ_GAP;
                    end
                end
                SQ_GAP: if (t_expired) begin
                    if (last) begin
                        state_q <= SQ_DONE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= SQ_ISSUE;
                    end
                end
                default: state_q <= SQ_DONE;
            endcase
        end
    end

    generate
        if (WIDE_BUS) begin : g_lane8
            assign req_data = step.code;
        end else begin : g_lane4
            lcdi_nibble_lane u_lane (
                .code  (step.code),
                .phase (phase_q),
                .lane  (req_data)
            );
        end
    endgenerate

    assign req_valid = (state_q == SQ_ISSUE);
    assign init_done = (state_q == SQ_DONE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_data))); // R4
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !req_valid); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R7
    AST_ISSUE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(t_expired)); // R5
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(cfg_q)); // R8
    AST_NIBBLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && more_nibble) |=> req_valid); // R6

endmodule

// File: tb/sim_lcdi_init_seq.sv
module sim_lcdi_init_seq;

    localparam int PWR = 40;
    localparam int FSW = 12;
    localparam int SHW = 9;
    localparam int CLW = 30;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic cl = 1'b0, cf = 1'b0, ci = 1'b0, cs = 1'b0;
    logic [1:0] vld;
    logic [1:0] rdy = 2'b00;
    logic [1:0] dn;
    logic [7:0] dat [2];

    lcdi_init_seq #(.WIDE_BUS(1'b1), .PWR_CYC(PWR), .FS_CYC(FSW), .SHORT_CYC(SHW),
                    .CLR_CYC(CLW), .DCB_BITS(3'b100)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_lines(cl), .cfg_font(cf), .cfg_incr(ci),
        .cfg_shift(cs), .req_ready(rdy[0]), .req_valid(vld[0]), .req_data(dat[0]),
        .init_done(dn[0]));

    lcdi_init_seq #(.WIDE_BUS(1'b0), .PWR_CYC(PWR), .FS_CYC(FSW), .SHORT_CYC(SHW),
                    .CLR_CYC(CLW), .DCB_BITS(3'b100)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_lines(cl), .cfg_font(cf), .cfg_incr(ci),
        .cfg_shift(cs), .req_ready(rdy[1]), .req_valid(vld[1]), .req_data(dat[1]),
        .init_done(dn[1]));

    int n_chk = 0;
    int n_bad = 0;
    int lat [2];
    int wc [2];
    int nlog [2];
    int idle [2];
    int dgap [2];
    int log_b [2][16];
    int log_g [2][16];
    logic [1:0] prev_hold;
    logic [1:0] was_done;
    logic [7:0] prev_dat [2];
    int hold_err = 0;
    int quiet_err = 0;
    int exp_b [16];
    int exp_g [16];
    int exp_n;
    int exp_dg;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Ready responder: one-cycle ready per request after lat[k] cycles.
    always @(posedge clk) begin
        #1;
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                rdy[k] = 1'b0; wc[k] = 0;
            end else if (rdy[k]) begin
                rdy[k] = 1'b0;
            end else if (vld[k]) begin
                if (wc[k] >= lat[k]) begin rdy[k] = 1'b1; wc[k] = 0; end
                else wc[k]++;
            end
        end
    end

    // Monitor: log accepted cycles and idle gaps; count protocol slips.
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                nlog[k] = 0; idle[k] = 0; dgap[k] = -1;
                prev_hold[k] = 1'b0; was_done[k] = 1'b0;
            end else begin
                if (prev_hold[k] && !(vld[k] && dat[k] == prev_dat[k])) hold_err++;
                if (dn[k] && vld[k]) quiet_err++;
                if (was_done[k] && !dn[k]) quiet_err++;
                if (vld[k] && rdy[k]) begin
                    if (nlog[k] < 16) begin
                        log_b[k][nlog[k]] = int'(dat[k]);
                        log_g[k][nlog[k]] = idle[k];
                    end
                    nlog[k]++;
                    idle[k] = 0;
                end else if (!vld[k] && !dn[k]) begin
                    idle[k]++;
                end
                if (dn[k] && dgap[k] < 0) dgap[k] = idle[k];
                prev_hold[k] = vld[k] && !rdy[k];
                prev_dat[k]  = dat[k];
                was_done[k]  = dn[k];
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Expected list for R2/R3/R5/R6/R7 from the captured config bits.
    task automatic build_exp(input int k, input logic l, input logic f, input logic i, input logic s);
        int fs, dc, em;
        dc = 8'h0C;
        em = 8'h04 | (int'(i) << 1) | int'(s);
        if (k == 0) begin
            fs = 8'h30 | (int'(l) << 3) | (int'(f) << 2);
            exp_n = 4;
            exp_b[0] = fs;   exp_g[0] = PWR;
            exp_b[1] = dc;   exp_g[1] = FSW;
            exp_b[2] = 8'h01; exp_g[2] = SHW;
            exp_b[3] = em;   exp_g[3] = CLW;
        end else begin
            fs = 8'h20 | (int'(l) << 3) | (int'(f) << 2);
            exp_n = 9;
            exp_b[0] = 8'h20;              exp_g[0] = PWR;
            exp_b[1] = fs & 8'hF0;         exp_g[1] = SHW;
            exp_b[2] = (fs << 4) & 8'hF0;  exp_g[2] = 0;
            exp_b[3] = dc & 8'hF0;         exp_g[3] = FSW;
            exp_b[4] = (dc << 4) & 8'hF0;  exp_g[4] = 0;
            exp_b[5] = 8'h00;              exp_g[5] = SHW;
            exp_b[6] = 8'h10;              exp_g[6] = 0;
            exp_b[7] = em & 8'hF0;         exp_g[7] = CLW;
            exp_b[8] = (em << 4) & 8'hF0;  exp_g[8] = 0;
        end
        exp_dg = SHW;
    endtask

    task automatic verify(input string tag, input logic l, input logic f, input logic i, input logic s);
        for (int k = 0; k < 2; k++) begin
            build_exp(k, l, f, i, s);
            chk({tag, (k == 0) ? " R2 count" : " R3 count"}, nlog[k], exp_n);
            for (int j = 0; j < exp_n && j < 16; j++) begin
                chk({tag, (k == 0) ? " R2 byte" : " R3 nibble"}, log_b[k][j], exp_b[j]);
                if (j == 0)            chk({tag, " R1 power wait"}, log_g[k][j], exp_g[j]);
                else if (exp_g[j] == 0) chk({tag, " R6 nibble gap"}, log_g[k][j], 0);
                else                   chk({tag, " R5 wait"}, log_g[k][j], exp_g[j]);
            end
            chk({tag, " R7 done delay"}, dgap[k], exp_dg);
            chk({tag, " R7 done level"}, int'(dn[k]), 1);
        end
        chk({tag, " R4 hold"}, hold_err, 0);
        chk({tag, " R7 quiet"}, quiet_err, 0);
    endtask

    task automatic apply_reset(input int cycles);
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (cycles) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int c = 0; c < 2000 && dn != 2'b11; c++) @(posedge clk);
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("reset R1 valid8", int'(vld[0]), 0);
        chk("reset R1 valid4", int'(vld[1]), 0);
        chk("reset R1 done", int'(dn), 0);
    endtask

    task automatic t_plain();
        lat[0] = 0; lat[1] = 0;
        cl = 1'b1; cf = 1'b0; ci = 1'b1; cs = 1'b0;
        apply_reset(3);
        wait_done();
        verify("plain", 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_stalled();
        lat[0] = 3; lat[1] = 2;
        cl = 1'b0; cf = 1'b1; ci = 1'b0; cs = 1'b1;
        apply_reset(2);
        wait_done();
        verify("stall", 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_cfg_frozen();
        lat[0] = 1; lat[1] = 0;
        cl = 1'b1; cf = 1'b1; ci = 1'b1; cs = 1'b1;
        apply_reset(2);
        @(posedge clk); #1;
        cl = 1'b0; cf = 1'b0; ci = 1'b0; cs = 1'b0;
        wait_done();
        verify("R8 frozen", 1'b1, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_restart();
        lat[0] = 0; lat[1] = 1;
        cl = 1'b0; cf = 1'b0; ci = 1'b1; cs = 1'b1;
        apply_reset(2);
        for (int c = 0; c < 2000 && !(nlog[0] >= 2 && nlog[1] >= 3); c++) @(posedge clk);
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9 valid in reset", int'(vld), 0);
        chk("R9 done in reset", int'(dn), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        wait_done();
        verify("R9 restart", 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        lat[0] = 0; lat[1] = 0;
        t_reset_state();
        t_plain();
        t_stalled();
        t_cfg_frozen();
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule